// File: doc/BRIEF.md
# Timer and Interrupt Sequencer

This controller sits beside a small processor core and decides when the core's program counter is redirected. It holds a free-running up-counter that restarts from zero whenever it reaches a programmed limit, and it watches one external interrupt line. Either source can raise a request. A request is honoured only at an instruction boundary: the controller then drives a fixed handler address onto its PC output with a load strobe, and it flips a bank-select line so that the core works from its alternate register set while the handler runs.

A return request swaps the bank back and reloads the PC that was current when the handler was entered. Handlers do not nest, because a global enable is dropped on entry and restored on return. The same counter also backs two stall conditions. A halt request freezes issue until an enabled request appears. A wait request holds the core until the counter shows a given value.

Top module: `tis_top`

## Requirements
- R1: After reset `pc_load`, `bank_sel` and `stall` are low, the counter holds 0, and interrupts are globally enabled.
- R2: The counter goes up by one every cycle. In a cycle where it equals `thresh` it returns to 0 on the next edge and flags a timer request.
- R3: `ext_pin` passes through two synchronising flip-flops. A rising edge on it produces a request that stays pending until it is taken. A line that stays high does not raise a second request.
- R4: When `insn_start` is high, the global enable is set and an enabled request is pending, `pc_load` is high in that same cycle. `pc_out` is 16'h0010 for the external source and 16'h0020 for the timer.
- R5: When both sources are pending at the same boundary, the external one is taken first. The timer request stays pending and is taken at a later boundary.
- R6: From the edge after entry, `bank_sel` is 1 and no further entry can happen until a return.
- R7: A `reti_req` while `bank_sel` is 1 raises `pc_load` in the same cycle, with `pc_out` equal to the `pc_in` value captured at entry. On the next edge it clears `bank_sel` and restores the global enable.
- R8: A `reti_req` while `bank_sel` is 0 is ignored: `pc_load` stays low and `bank_sel` stays 0.
- R9: A one-cycle `halt_req` makes `stall` high from the next cycle. `stall` stays high until an enabled request is pending with the global enable set. A pending request from a disabled source does not end the halt.
- R10: While `wait_req` is high, `stall` is high in every cycle where the counter differs from `wait_val`, and low in the cycle where they are equal.
- R11: A pending request whose enable bit is 0 is not taken (`src_en[0]` is external, `src_en[1]` is timer). It stays pending and is taken once its bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt line |
| pc_in | input | 16 | Core's current PC, captured at entry |
| insn_start | input | 1 | High in the first cycle of an instruction |
| halt_req | input | 1 | Request to halt until an interrupt |
| wait_req | input | 1 | Hold the core until the counter matches `wait_val` |
| wait_val | input | 16 | Counter value that ends a wait |
| reti_req | input | 1 | Return-from-handler request |
| thresh | input | 16 | Counter limit that raises the timer request |
| src_en | input | 2 | Per-source enable: bit 0 external, bit 1 timer |
| pc_out | output | 16 | Address to load into the PC |
| pc_load | output | 1 | Load strobe for `pc_out` |
| bank_sel | output | 1 | 1 while the alternate register set is in use |
| stall | output | 1 | Freeze instruction issue |

## Verification
The embedded properties check several things on every cycle: the counter's single-step progress and its restart after a limit match, that a pending external request is held, that the external source takes precedence, the bank swap after entry and after return, that an idle return is ignored, and the release of a wait on the matching cycle. Other behaviour can only be shown by the directed scenarios. These cover how many cycles the external edge takes to reach the core, that a level held high does not trigger again, that the right PC comes back after a handler, that a masked request survives until it is enabled, and that a halt ignores disabled sources but ends on an enabled one.

// File: rtl/tis_pkg.sv
package tis_pkg;

    localparam int unsigned PC_W = 16;

    localparam logic [PC_W-1:0] EXT_ENTRY = 16'h0010;
    localparam logic [PC_W-1:0] TMR_ENTRY = 16'h0020;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_TMR  = 2'd2
    } src_e;

    typedef struct packed {
        logic ext;
        logic tmr;
    } req_t;

    // External source wins a tie.
    function automatic src_e pick_src(input req_t r);
        if (r.ext)      return SRC_EXT;
        else if (r.tmr) return SRC_TMR;
        else            return SRC_NONE;
    endfunction

    function automatic logic [PC_W-1:0] entry_of(input src_e s);
        case (s)
            SRC_EXT: return EXT_ENTRY;
            SRC_TMR: return TMR_ENTRY;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/tis_sync_edge.sv
module tis_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic clr,
    output logic pend
);
    localparam int unsigned LAST = STAGES;

    logic [LAST:0] sh_q;
    logic          rise;

    assign rise = sh_q[LAST-1] & ~sh_q[LAST];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            pend <= 1'b0;
        end else begin
            sh_q <= {sh_q[LAST-1:0], pin};
            if (rise)     pend <= 1'b1;
            else if (clr) pend <= 1'b0;
        end
    end

    // R3: a pending request is kept until the sequencer takes it
    p_pend_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);

endmodule

// File: rtl/tis_timer.sv
module tis_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] thresh,
    input  logic         clr,
    input  logic         wait_req,
    input  logic [W-1:0] wait_val,
    output logic         pend,
    output logic         wait_stall
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic         hit;

    assign hit        = (cnt_q == thresh);
    assign wait_stall = wait_req && (cnt_q != wait_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pend  <= 1'b0;
        end else begin
            cnt_q <= hit ? '0 : cnt_q + ONE;
            if (hit)      pend <= 1'b1;
            else if (clr) pend <= 1'b0;
        end
    end

    // R2: single step when no limit match
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != thresh) |=> (cnt_q == $past(cnt_q) + ONE));

    // R2: restart from zero and request after a match
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == thresh) |=> (cnt_q == '0 && pend));

    // R10: a wait is released in the matching cycle
    p_wait_rel_r10: assert property (@(posedge clk) disable iff (rst)
        (wait_req && cnt_q == wait_val) |-> !wait_stall);

endmodule

// File: rtl/tis_seq.sv
module tis_seq
    import tis_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            insn_start,
    input  logic [PC_W-1:0] pc_in,
    input  logic            halt_req,
    input  logic            reti_req,
    input  req_t            pend,
    input  logic [1:0]      src_en,
    input  logic            wait_stall,
    output logic [PC_W-1:0] pc_out,
    output logic            pc_load,
    output logic            bank_sel,
    output logic            stall,
    output logic            clr_ext,
    output logic            clr_tmr
);
    logic            gie_q;
    logic            bank_q;
    logic            halted_q;
    logic [PC_W-1:0] ret_pc_q;

    req_t avail;
    src_e sel;
    logic wake;
    logic take;
    logic do_ret;

    always_comb begin
        avail.ext = pend.ext & src_en[0];
        avail.tmr = pend.tmr & src_en[1];
        sel       = pick_src(avail);
        wake      = gie_q & (avail.ext | avail.tmr);
        take      = insn_start & wake;
        do_ret    = reti_req & bank_q;
        pc_load   = take | do_ret;
        if (take)        pc_out = entry_of(sel);
        else if (do_ret) pc_out = ret_pc_q;
        else             pc_out = '0;
        clr_ext   = take && (sel == SRC_EXT);
        clr_tmr   = take && (sel == SRC_TMR);
        stall     = (halted_q & ~wake) | wait_stall;
    end

    assign bank_sel = bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q    <= 1'b1;
            bank_q   <= 1'b0;
            halted_q <= 1'b0;
            ret_pc_q <= '0;
        end else begin
            if (take) begin
                gie_q    <= 1'b0;
                bank_q   <= 1'b1;
                ret_pc_q <= pc_in;
            end else if (do_ret) begin
                gie_q    <= 1'b1;
                bank_q   <= 1'b0;
            end
            if (wake)          halted_q <= 1'b0;
            else if (halt_req) halted_q <= 1'b1;
        end
    end

    // R6: the alternate bank is selected after an entry
    p_entry_bank_r6: assert property (@(posedge clk) disable iff (rst)
        take |=> (bank_sel && !gie_q));

    // R6: no entry while a handler is active
    p_no_nest_r6: assert property (@(posedge clk) disable iff (rst)
        (bank_sel && !reti_req) |-> !pc_load);

    // R5: external request has precedence
    p_prio_r5: assert property (@(posedge clk) disable iff (rst)
        (insn_start && gie_q && pend.ext && src_en[0]) |-> (pc_load && pc_out == EXT_ENTRY));

    // R7: return swaps back and re-enables
    p_ret_r7: assert property (@(posedge clk) disable iff (rst)
        (reti_req && bank_sel) |=> (!bank_sel && gie_q));

    // R8: return outside a handler has no effect
    p_idle_ret_r8: assert property (@(posedge clk) disable iff (rst)
        (reti_req && !bank_sel && !insn_start) |-> !pc_load);

endmodule

// File: rtl/tis_top.sv
module tis_top
    import tis_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic [PC_W-1:0]  pc_in,
    input  logic             insn_start,
    input  logic             halt_req,
    input  logic             wait_req,
    input  logic [CNT_W-1:0] wait_val,
    input  logic             reti_req,
    input  logic [CNT_W-1:0] thresh,
    input  logic [1:0]       src_en,
    output logic [PC_W-1:0]  pc_out,
    output logic             pc_load,
    output logic             bank_sel,
    output logic             stall
);
    req_t pend;
    logic clr_ext;
    logic clr_tmr;
    logic wait_stall;
    logic ext_p;
    logic tmr_p;

    tis_sync_edge #(.STAGES(SYNC_STAGES)) u_ext (
        .clk (clk),
        .rst (rst),
        .pin (ext_pin),
        .clr (clr_ext),
        .pend(ext_p)
    );

    tis_timer #(.W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .thresh    (thresh),
        .clr       (clr_tmr),
        .wait_req  (wait_req),
        .wait_val  (wait_val),
        .pend      (tmr_p),
        .wait_stall(wait_stall)
    );

    assign pend.ext = ext_p;
    assign pend.tmr = tmr_p;

    tis_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .insn_start(insn_start),
        .pc_in     (pc_in),
        .halt_req  (halt_req),
        .reti_req  (reti_req),
        .pend      (pend),
        .src_en    (src_en),
        .wait_stall(wait_stall),
        .pc_out    (pc_out),
        .pc_load   (pc_load),
        .bank_sel  (bank_sel),
        .stall     (stall),
        .clr_ext   (clr_ext),
        .clr_tmr   (clr_tmr)
    );

endmodule

// File: tb/tis_top_test.sv
module tis_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ext_pin;
    logic [15:0] pc_in;
    logic        insn_start;
    logic        halt_req;
    logic        wait_req;
    logic [15:0] wait_val;
    logic        reti_req;
    logic [15:0] thresh;
    logic [1:0]  src_en;
    logic [15:0] pc_out;
    logic        pc_load;
    logic        bank_sel;
    logic        stall;

    int checks   = 0;
    int failures = 0;
    logic [15:0] exp_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    tis_top uut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .pc_in(pc_in),
        .insn_start(insn_start), .halt_req(halt_req), .wait_req(wait_req),
        .wait_val(wait_val), .reti_req(reti_req), .thresh(thresh),
        .src_en(src_en), .pc_out(pc_out), .pc_load(pc_load),
        .bank_sel(bank_sel), .stall(stall)
    );

    // counter expectation from R2
    always @(posedge clk) begin
        if (rst)                 exp_cnt <= 16'd0;
        else if (exp_cnt == thresh) exp_cnt <= 16'd0;
        else                     exp_cnt <= exp_cnt + 16'd1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] th);
        @(negedge clk);
        rst = 1; ext_pin = 0; pc_in = 16'h0; insn_start = 0; halt_req = 0;
        wait_req = 0; wait_val = 0; reti_req = 0; thresh = th; src_en = 2'b00;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset;
        do_reset(16'hFFFF);
        #1;
        check(pc_load == 0, "R1", pc_load, 0);
        check(bank_sel == 0, "R1", bank_sel, 0);
        check(stall == 0, "R1", stall, 0);
        wait_req = 1; wait_val = 16'd0; #1;
        check(stall == 0, "R1 count zero", stall, 0);
        wait_req = 0;
    endtask

    task automatic t_wait;
        do_reset(16'hFFFF);
        repeat (3) @(negedge clk);
        wait_val = exp_cnt + 16'd3; wait_req = 1; #1;
        check(stall == 1, "R10", stall, 1);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk); #1;
            check(stall == (i < 3), "R10", stall, (i < 3));
        end
        @(negedge clk); wait_req = 0;
        do_reset(16'd5);
        while (exp_cnt != 16'd4) @(negedge clk);
        wait_val = 16'd0; wait_req = 1; #1;
        check(stall == 1, "R2 before limit", stall, 1);
        @(negedge clk); #1;
        check(stall == 1, "R2 at limit", stall, 1);
        @(negedge clk); #1;
        check(stall == 0, "R2 wrap to zero", stall, 0);
        wait_req = 0;
    endtask

    task automatic t_timer_irq;
        bit seen;
        do_reset(16'd4);
        src_en = 2'b10; pc_in = 16'h1234; insn_start = 1;
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk); #1;
            if (pc_load) seen = 1;
        end
        check(seen, "R4 timer entry", seen, 1);
        check(pc_out == 16'h0020, "R4 timer address", pc_out, 16'h0020);
        check(exp_cnt == 16'd0, "R2 request at wrap", exp_cnt, 0);
        @(negedge clk); pc_in = 16'h5555; #1;
        check(bank_sel == 1, "R6 bank", bank_sel, 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            check(pc_load == 0, "R6 no nesting", pc_load, 0);
        end
        insn_start = 0; reti_req = 1; #1;
        check(pc_load == 1, "R7 return load", pc_load, 1);
        check(pc_out == 16'h1234, "R7 return pc", pc_out, 16'h1234);
        @(negedge clk); reti_req = 0; #1;
        check(bank_sel == 0, "R7 bank back", bank_sel, 0);
        insn_start = 1; #1;
        check(pc_load == 1 && pc_out == 16'h0020, "R7 enable restored", pc_out, 16'h0020);
        @(negedge clk); insn_start = 0;
    endtask

    task automatic t_ext_irq;
        do_reset(16'hFFFF);
        src_en = 2'b01; insn_start = 1; pc_in = 16'h0400;
        ext_pin = 1; #1;
        check(pc_load == 0, "R3 sync delay", pc_load, 0);
        for (int i = 1; i <= 2; i++) begin
            @(negedge clk); #1;
            check(pc_load == 0, "R3 sync delay", pc_load, 0);
        end
        @(negedge clk); #1;
        check(pc_load == 1, "R4 ext entry", pc_load, 1);
        check(pc_out == 16'h0010, "R4 ext address", pc_out, 16'h0010);
        @(negedge clk); insn_start = 0; reti_req = 1; #1;
        check(pc_out == 16'h0400 && pc_load, "R7 ext return", pc_out, 16'h0400);
        @(negedge clk); reti_req = 0; insn_start = 1;
        for (int i = 0; i < 6; i++) begin
            #1; check(pc_load == 0, "R3 level no retrigger", pc_load, 0);
            @(negedge clk);
        end
        insn_start = 0;
    endtask

    task automatic t_priority;
        do_reset(16'd3);
        insn_start = 1; ext_pin = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            check(pc_load == 0, "R11 masked", pc_load, 0);
        end
        src_en = 2'b11; #1;
        check(pc_load == 1 && pc_out == 16'h0010, "R5 ext first", pc_out, 16'h0010);
        @(negedge clk); insn_start = 0; reti_req = 1;
        @(negedge clk); reti_req = 0; insn_start = 1; #1;
        check(pc_load == 1 && pc_out == 16'h0020, "R5 timer later", pc_out, 16'h0020);
        @(negedge clk); insn_start = 0;
    endtask

    task automatic t_reti_idle;
        do_reset(16'hFFFF);
        reti_req = 1; #1;
        check(pc_load == 0, "R8 idle return", pc_load, 0);
        @(negedge clk); reti_req = 0; #1;
        check(bank_sel == 0, "R8 bank unchanged", bank_sel, 0);
    endtask

    task automatic t_halt;
        do_reset(16'd2);
        src_en = 2'b01; halt_req = 1;
        @(negedge clk); halt_req = 0; #1;
        check(stall == 1, "R9 halt", stall, 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            check(stall == 1, "R9 disabled source", stall, 1);
        end
        ext_pin = 1; #1;
        check(stall == 1, "R9 still halted", stall, 1);
        for (int i = 1; i <= 2; i++) begin
            @(negedge clk); #1;
            check(stall == 1, "R9 still halted", stall, 1);
        end
        @(negedge clk); #1;
        check(stall == 0, "R9 wake", stall, 0);
    endtask

    initial begin
        rst = 1;
        t_reset();
        t_wait();
        t_timer_irq();
        t_ext_irq();
        t_priority();
        t_reti_idle();
        t_halt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule